// File: doc/BRIEF.md
# Video Mode Switch Shadow

This block sits on an 8-bit host bus as a silent listener. It never drives the bus. It watches each qualified bus cycle and keeps a private copy of the host's display mode switches, a text/background colour byte and a border colour nibble. A display engine elsewhere on the chip reads that copy, so it always follows the mode the host software has selected.

Only a 128-byte window of the I/O space is decoded. Most switches are set/clear pairs: one offset clears the bit and its neighbour sets it. Some pairs respond to any access, read or write, because the host treats a simple read of the address as the command. Others respond only to writes, and only when a configuration input says the host machine model has that register. Two inputs name the model: `cfg_enh` (enhanced) and `cfg_adv` (advanced). An advanced host also has colour registers and two multi-bit fields, and a write replaces those wholesale.

Top module: `vid_switch_snoop`

## Requirements
- R1: While `rst_n` is low, and after it is released with no bus activity, `sw_vec` is all zeros, `tb_color` is 0x00 and `border_color` is 0x0.
- R2: Only cycles whose address ANDed with 0xFF80 equals 0xC000 are decoded. All other addresses leave every output unchanged. The switch is picked by `bus_addr[6:0]`.
- R3: Offsets 0x50/0x51 clear/set `sw_vec[0]` (text), 0x52/0x53 clear/set `sw_vec[1]` (mixed), 0x54/0x55 clear/set `sw_vec[2]` (second page) and 0x56/0x57 clear/set `sw_vec[3]` (high resolution). Each acts on reads and writes alike, whatever the model inputs.
- R4: On write cycles (`bus_rw_n` = 0) only, and only when `cfg_enh` or `cfg_adv` is high, these offsets clear/set their bit: 0x00/0x01 `sw_vec[4]` (store-80), 0x04/0x05 `sw_vec[5]` (auxiliary write), 0x08/0x09 `sw_vec[6]` (auxiliary zero page), 0x0C/0x0D `sw_vec[7]` (80 columns) and 0x0E/0x0F `sw_vec[8]` (alternate characters).
- R5: A write to 0x21 with `cfg_enh` or `cfg_adv` high copies `bus_data[7]` into `sw_vec[9]` (monochrome). A read of 0x21 has no effect.
- R6: With `cfg_adv` high, a write to 0x22 loads all of `bus_data` into `tb_color`, and a write to 0x34 loads `bus_data[3:0]` into `border_color`. Without `cfg_adv`, or on a read, neither register changes.
- R7: With `cfg_adv` high, a write to 0x29 copies `bus_data[7:5]` into `sw_vec[14:12]`, and a write to 0x35 copies `bus_data[6:0]` into `sw_vec[21:15]`. Every other bit of `sw_vec` keeps its value.
- R8: With `cfg_enh` or `cfg_adv` high, offset 0x5E sets and 0x5F clears `sw_vec[10]` (double graphics) on any access.
- R9: Offset 0x7E sets and 0x7F clears `sw_vec[11]` (I/O disable). This happens only on writes and only when `cfg_enh` is high. `cfg_adv` alone does not enable it.
- R10: A cycle with `cyc_valid` low, an offset not listed above, or a listed offset whose model or direction condition is not met leaves every output unchanged.
- R11: An accepted update appears on the outputs right after the first rising clock edge at which `cyc_valid` is high, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | One-clock pulse qualifying a bus cycle |
| bus_addr | input | 16 | Bus address of the cycle |
| bus_data | input | 8 | Bus data of the cycle |
| bus_rw_n | input | 1 | High for a read, low for a write |
| cfg_enh | input | 1 | Host has the enhanced-model registers |
| cfg_adv | input | 1 | Host has the advanced-model registers |
| sw_vec | output | 22 | Packed switch vector |
| tb_color | output | 8 | Text/background colour byte |
| border_color | output | 4 | Border colour |

## Verification
The assertions assume that `cyc_valid` is high for exactly one clock per bus cycle. They also assume that the address, data and direction are stable during that clock, and that the model inputs only change between cycles. The bench keeps to these assumptions. Each cycle is driven on a falling edge, with one `cyc_valid` clock per task call, and the model inputs are changed only while `cyc_valid` is low. Results are then read on the next falling edge, once the single register stage has updated.

// File: rtl/vid_switch_snoop.sv
module vid_switch_snoop #(
  parameter logic [15:0] WIN_BASE = 16'hC000,
  parameter int NV_W = 3,
  parameter int SH_W = 7,
  localparam int NV_LSB = 12,
  localparam int SH_LSB = NV_LSB + NV_W,
  localparam int SW_W = SH_LSB + SH_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_valid,
  input  logic [15:0]     bus_addr,
  input  logic [7:0]      bus_data,
  input  logic            bus_rw_n,
  input  logic            cfg_enh,
  input  logic            cfg_adv,
  output logic [SW_W-1:0] sw_vec,
  output logic [7:0]      tb_color,
  output logic [3:0]      border_color
);

  localparam int B_TEXT  = 0;
  localparam int B_MIX   = 1;
  localparam int B_PG2   = 2;
  localparam int B_HIRES = 3;
  localparam int B_ST80  = 4;
  localparam int B_AUXWR = 5;
  localparam int B_AUXZP = 6;
  localparam int B_COL80 = 7;
  localparam int B_ALTCH = 8;
  localparam int B_MONO  = 9;
  localparam int B_DGFX  = 10;
  localparam int B_IODIS = 11;

  wire        hit   = cyc_valid && ((bus_addr & 16'hFF80) == WIN_BASE);
  wire [6:0]  off   = bus_addr[6:0];
  wire        wr    = !bus_rw_n;
  wire        any_m = cfg_enh || cfg_adv;
  wire        ew    = wr && any_m;
  wire        aw    = wr && cfg_adv;

  logic [SW_W-1:0] sw_n;
  logic [7:0]      tb_n;
  logic [3:0]      bd_n;

  always_comb begin
    sw_n = sw_vec;
    tb_n = tb_color;
    bd_n = border_color;
    if (hit) begin
      case (off)
        7'h50: sw_n[B_TEXT]  = 1'b0;
        7'h51: sw_n[B_TEXT]  = 1'b1;
        7'h52: sw_n[B_MIX]   = 1'b0;
        7'h53: sw_n[B_MIX]   = 1'b1;
        7'h54: sw_n[B_PG2]   = 1'b0;
        7'h55: sw_n[B_PG2]   = 1'b1;
        7'h56: sw_n[B_HIRES] = 1'b0;
        7'h57: sw_n[B_HIRES] = 1'b1;
        7'h00: if (ew) sw_n[B_ST80]  = 1'b0;
        7'h01: if (ew) sw_n[B_ST80]  = 1'b1;
        7'h04: if (ew) sw_n[B_AUXWR] = 1'b0;
        7'h05: if (ew) sw_n[B_AUXWR] = 1'b1;
        7'h08: if (ew) sw_n[B_AUXZP] = 1'b0;
        7'h09: if (ew) sw_n[B_AUXZP] = 1'b1;
        7'h0C: if (ew) sw_n[B_COL80] = 1'b0;
        7'h0D: if (ew) sw_n[B_COL80] = 1'b1;
        7'h0E: if (ew) sw_n[B_ALTCH] = 1'b0;
        7'h0F: if (ew) sw_n[B_ALTCH] = 1'b1;
        7'h21: if (ew) sw_n[B_MONO]  = bus_data[7];
        7'h22: if (aw) tb_n = bus_data;
        7'h34: if (aw) bd_n = bus_data[3:0];
        7'h29: if (aw) sw_n[SH_LSB-1:NV_LSB] = bus_data[7 -: NV_W];
        7'h35: if (aw) sw_n[SW_W-1:SH_LSB]   = bus_data[SH_W-1:0];
        7'h5E: if (any_m) sw_n[B_DGFX] = 1'b1;
        7'h5F: if (any_m) sw_n[B_DGFX] = 1'b0;
        7'h7E: if (wr && cfg_enh) sw_n[B_IODIS] = 1'b1;
        7'h7F: if (wr && cfg_enh) sw_n[B_IODIS] = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_vec       <= '0;
      tb_color     <= '0;
      border_color <= '0;
    end else begin
      sw_vec       <= sw_n;
      tb_color     <= tb_n;
      border_color <= bd_n;
    end
  end

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |=> $stable(sw_vec) && $stable(tb_color) && $stable(border_color));

  assert_window_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && ((bus_addr & 16'hFF80) != WIN_BASE)
    |=> $stable(sw_vec) && $stable(tb_color) && $stable(border_color));

  assert_read_no_wo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && bus_rw_n
    |=> $stable(sw_vec[B_MONO:B_ST80]) && $stable(sw_vec[B_IODIS])
        && $stable(sw_vec[SW_W-1:NV_LSB]) && $stable(tb_color) && $stable(border_color));

  assert_text_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && (bus_addr == (WIN_BASE | 16'h0051)) |=> sw_vec[B_TEXT]);

  assert_border_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && !bus_rw_n && cfg_adv && (bus_addr == (WIN_BASE | 16'h0034))
    |=> border_color == $past(bus_data[3:0]));

  assert_adv_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && !cfg_adv
    |=> $stable(sw_vec[SW_W-1:NV_LSB]) && $stable(tb_color) && $stable(border_color));

  assert_iodis_enh_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && !cfg_enh |=> $stable(sw_vec[B_IODIS]));

  assert_no_model_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && !cfg_enh && !cfg_adv |=> $stable(sw_vec[SW_W-1:B_ST80]));

endmodule

// File: tb/vid_switch_snoop_bench.sv
module vid_switch_snoop_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_valid = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic        bus_rw_n = 1'b1;
  logic        cfg_enh = 1'b0;
  logic        cfg_adv = 1'b0;
  logic [21:0] sw_vec;
  logic [7:0]  tb_color;
  logic [3:0]  border_color;

  int n_run = 0;
  int n_fail = 0;
  logic [21:0] e_sw = '0;
  logic [7:0]  e_tb = '0;
  logic [3:0]  e_bd = '0;

  always #10 clk = ~clk;

  vid_switch_snoop u_vid_switch_snoop (
    .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_rw_n(bus_rw_n), .cfg_enh(cfg_enh), .cfg_adv(cfg_adv),
    .sw_vec(sw_vec), .tb_color(tb_color), .border_color(border_color));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " sw_vec"}, 32'(sw_vec), 32'(e_sw));
    chk({req, " tb_color"}, 32'(tb_color), 32'(e_tb));
    chk({req, " border"}, 32'(border_color), 32'(e_bd));
  endtask

  task automatic cyc(input logic [15:0] a, input logic [7:0] d, input logic rn);
    @(negedge clk);
    bus_addr = a; bus_data = d; bus_rw_n = rn; cyc_valid = 1'b1;
    @(negedge clk);
    cyc_valid = 1'b0;
  endtask

  task automatic set_model(input logic enh, input logic adv);
    @(negedge clk);
    cfg_enh = enh; cfg_adv = adv;
  endtask

  task automatic t_reset;
    chk_all("R1 reset");
  endtask

  task automatic t_display;
    cyc(16'hC051, 8'h00, 1'b1); e_sw[0] = 1'b1;
    cyc(16'hC053, 8'h00, 1'b0); e_sw[1] = 1'b1;
    cyc(16'hC055, 8'h00, 1'b1); e_sw[2] = 1'b1;
    cyc(16'hC057, 8'h00, 1'b0); e_sw[3] = 1'b1;
    chk_all("R3 set pairs");
    cyc(16'hC050, 8'h00, 1'b0); e_sw[0] = 1'b0;
    cyc(16'hC054, 8'h00, 1'b1); e_sw[2] = 1'b0;
    chk_all("R3 clear pairs");
  endtask

  task automatic t_model_pairs;
    cyc(16'hC001, 8'h00, 1'b0);
    chk_all("R4 no model flag");
    set_model(1'b1, 1'b0);
    cyc(16'hC005, 8'h00, 1'b1);
    chk_all("R4 read ignored");
    cyc(16'hC001, 8'h00, 1'b0); e_sw[4] = 1'b1;
    cyc(16'hC005, 8'h00, 1'b0); e_sw[5] = 1'b1;
    cyc(16'hC009, 8'h00, 1'b0); e_sw[6] = 1'b1;
    cyc(16'hC00D, 8'h00, 1'b0); e_sw[7] = 1'b1;
    cyc(16'hC00F, 8'h00, 1'b0); e_sw[8] = 1'b1;
    chk_all("R4 enhanced writes set");
    set_model(1'b0, 1'b1);
    cyc(16'hC004, 8'h00, 1'b0); e_sw[5] = 1'b0;
    cyc(16'hC00C, 8'h00, 1'b0); e_sw[7] = 1'b0;
    chk_all("R4 advanced writes clear");
  endtask

  task automatic t_mono;
    set_model(1'b1, 1'b0);
    cyc(16'hC021, 8'h80, 1'b0); e_sw[9] = 1'b1;
    chk_all("R5 mono set");
    cyc(16'hC021, 8'h7F, 1'b1);
    chk_all("R5 read ignored");
    cyc(16'hC021, 8'h7F, 1'b0); e_sw[9] = 1'b0;
    chk_all("R5 mono clear");
  endtask

  task automatic t_colors;
    set_model(1'b1, 1'b0);
    cyc(16'hC022, 8'hA5, 1'b0);
    cyc(16'hC034, 8'h0C, 1'b0);
    chk_all("R6 enhanced only ignored");
    set_model(1'b0, 1'b1);
    cyc(16'hC022, 8'hA5, 1'b0); e_tb = 8'hA5;
    cyc(16'hC034, 8'hF9, 1'b0); e_bd = 4'h9;
    chk_all("R6 advanced loads");
    cyc(16'hC022, 8'h11, 1'b1);
    chk_all("R6 read ignored");
  endtask

  task automatic t_fields;
    set_model(1'b0, 1'b1);
    cyc(16'hC029, 8'hBF, 1'b0); e_sw[14:12] = 3'b101;
    chk_all("R7 new-video field");
    cyc(16'hC035, 8'hD3, 1'b0); e_sw[21:15] = 7'h53;
    chk_all("R7 shadow field");
    set_model(1'b1, 1'b0);
    cyc(16'hC035, 8'h00, 1'b0);
    chk_all("R7 needs advanced");
  endtask

  task automatic t_dgfx;
    set_model(1'b0, 1'b0);
    cyc(16'hC05E, 8'h00, 1'b1);
    chk_all("R8 no model");
    set_model(1'b0, 1'b1);
    cyc(16'hC05E, 8'h00, 1'b1); e_sw[10] = 1'b1;
    chk_all("R8 read sets");
    cyc(16'hC05F, 8'h00, 1'b0); e_sw[10] = 1'b0;
    chk_all("R8 write clears");
  endtask

  task automatic t_iodis;
    set_model(1'b0, 1'b1);
    cyc(16'hC07E, 8'h00, 1'b0);
    chk_all("R9 advanced alone ignored");
    set_model(1'b1, 1'b0);
    cyc(16'hC07E, 8'h00, 1'b1);
    chk_all("R9 read ignored");
    cyc(16'hC07E, 8'h00, 1'b0); e_sw[11] = 1'b1;
    chk_all("R9 enhanced write sets");
    cyc(16'hC07F, 8'h00, 1'b0); e_sw[11] = 1'b0;
    chk_all("R9 enhanced write clears");
  endtask

  task automatic t_ignore;
    set_model(1'b1, 1'b1);
    @(negedge clk);
    bus_addr = 16'hC051; bus_rw_n = 1'b0; cyc_valid = 1'b0;
    @(negedge clk);
    chk_all("R10 valid low");
    cyc(16'hC030, 8'hFF, 1'b0);
    cyc(16'hC07D, 8'hFF, 1'b0);
    chk_all("R10 unlisted offsets");
    cyc(16'hC0D1, 8'h00, 1'b0);
    cyc(16'h4051, 8'h00, 1'b1);
    cyc(16'hC151, 8'h00, 1'b1);
    chk_all("R2 outside window");
  endtask

  task automatic t_latency;
    @(negedge clk);
    bus_addr = 16'hC057; bus_data = 8'h00; bus_rw_n = 1'b1; cyc_valid = 1'b1;
    e_sw[3] = 1'b0; cyc(16'hC056, 8'h00, 1'b1);
    @(negedge clk);
    bus_addr = 16'hC051; bus_rw_n = 1'b1; cyc_valid = 1'b1;
    @(posedge clk);
    #1;
    chk("R11 after edge", 32'(sw_vec[0]), 32'd1);
    cyc_valid = 1'b0;
    @(negedge clk);
    bus_addr = 16'hC050; cyc_valid = 1'b1;
    #2;
    chk("R11 before edge", 32'(sw_vec[0]), 32'd1);
    @(posedge clk);
    #1;
    cyc_valid = 1'b0;
    chk("R11 next edge", 32'(sw_vec[0]), 32'd0);
    e_sw[0] = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_all("R1 after release");
    t_display;
    t_model_pairs;
    t_mono;
    t_colors;
    t_fields;
    t_dgfx;
    t_iodis;
    t_ignore;
    t_latency;
    @(negedge clk);
    chk_all("R11 final state");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule